// File: doc/BRIEF.md
# Peripheral Call Stall Controller

This block lets a CPU whose instructions each take one clock cycle hand slow work to a peripheral without interrupts or polling loops. The CPU reports each no-operation instruction it issues, along with that instruction's 5-bit operand. A zero operand does nothing. A nonzero operand is latched as a pending call code. The block raises a busy output, and the CPU datapath uses it to freeze its program counter and register writes. The block drops busy once the peripheral that owns the code has finished its work and the code has been cleared.

Two codes are bound to serial adapters. The transmit call offers the byte already sitting in the CPU's 8-bit serial output port on a byte-wide valid/ready interface towards a UART transmitter. The receive call waits for a received-byte strobe from a UART receiver and stores the byte in the CPU's 8-bit serial input port register. The bit-timing engines that run the 9600 baud link are outside this block. Any other nonzero code is released after one cycle, so a stray code cannot lock up the CPU.

Top module: `pcall_ctrl`

## Requirements
- R1: After reset, busy is low, pending_code is 0, tx_valid is low and ser_in_port is 0x00.
- R2: A NOP with operand 0 (nop_valid high, nop_operand 0) leaves busy low and pending_code at 0 in the next cycle.
- R3: A NOP with a nonzero operand, issued while busy is low, drives busy high in the next cycle with pending_code equal to that operand. Busy then stays high until the call completes.
- R4: While code 2 (serial output call) is pending and the byte has not yet been accepted, tx_valid is high and tx_data equals ser_out_port. Both are held while tx_ready is low.
- R5: When tx_valid and tx_ready are both high in a cycle, tx_valid is low in the next cycle, busy is still high in that cycle, and busy is low in the cycle after it.
- R6: While code 1 (serial input call) is pending, a cycle with rx_strobe high loads rx_byte into ser_in_port by the next cycle. Busy stays high in that next cycle and is low one cycle later.
- R7: rx_strobe has no effect on ser_in_port unless a code-1 call is pending and has not yet captured a byte.
- R8: A pending code other than 0, 1 or 2 keeps busy high for exactly one cycle.
- R9: A NOP issued while busy is high is ignored. pending_code keeps its value and the stall ends according to the original code.
- R10: tx_valid is never high unless code 2 is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nop_valid | input | 1 | CPU is executing a no-operation instruction this cycle |
| nop_operand | input | 5 | Operand of that instruction (call code) |
| busy | output | 1 | Stall request: hold PC and register updates |
| pending_code | output | 5 | Call code currently latched, 0 when idle |
| ser_out_port | input | 8 | CPU serial output port contents |
| tx_data | output | 8 | Byte offered to the UART transmitter |
| tx_valid | output | 1 | Byte offer valid |
| tx_ready | input | 1 | Transmitter accepts the byte |
| rx_byte | input | 8 | Byte from the UART receiver |
| rx_strobe | input | 1 | One-cycle pulse: rx_byte is new |
| ser_in_port | output | 8 | CPU serial input port register |

## Verification
Operand patterns are chosen to separate the cases that decode differently. Zero should cause no stall. Codes 1 and 2 should route to the right adapter, and an unassigned code (7) should release after one cycle. The transmit call is run with tx_ready held low for several cycles before the accept, which shows that the offer is held stable and is not a one-cycle pulse. Receive strobes are sent with no call pending and during a transmit call, as well as during a receive call, so that the bench can tell a correctly gated capture from one that follows every strobe. A second NOP issued during a stall shows whether the pending code can be overwritten.

// File: rtl/pcall_pkg.sv
package pcall_pkg;
  localparam int unsigned CODE_W   = 5;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned CODE_SIN = 1;
  localparam int unsigned CODE_SOUT = 2;
endpackage

// File: rtl/pcall_rst_sync.sv
module pcall_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/pcall_code_reg.sv
module pcall_code_reg #(
  parameter int unsigned CODE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nop_valid,
  input  logic [CODE_W-1:0] nop_operand,
  input  logic              done,
  output logic [CODE_W-1:0] code_q
);
  logic [CODE_W-1:0] code_d;
  logic              code_en;
  logic              idle;

  assign idle = (code_q == '0);

  always_comb begin
    code_en = 1'b0;
    code_d  = code_q;
    if (idle) begin
      if (nop_valid && (nop_operand != '0)) begin
        code_en = 1'b1;
        code_d  = nop_operand;
      end
    end else if (done) begin
      code_en = 1'b1;
      code_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       code_q <= '0;
    else if (code_en) code_q <= code_d;
  end
endmodule

// File: rtl/pcall_tx_adapter.sv
module pcall_tx_adapter #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic [BYTE_W-1:0] port_byte,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data,
  output logic              done
);
  logic sent_q;
  logic sent_d;
  logic fire;

  assign tx_valid = sel && !sent_q;
  assign tx_data  = port_byte;
  assign fire     = tx_valid && tx_ready;

  always_comb begin
    sent_d = sel && (sent_q || fire);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sent_q <= 1'b0;
    else        sent_q <= sent_d;
  end

  assign done = sel && sent_q;
endmodule

// File: rtl/pcall_rx_adapter.sv
module pcall_rx_adapter #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              rx_strobe,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic [BYTE_W-1:0] port_q,
  output logic              done
);
  logic got_q;
  logic got_d;
  logic capture;

  assign capture = sel && !got_q && rx_strobe;

  always_comb begin
    got_d = sel && (got_q || capture);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) got_q <= 1'b0;
    else        got_q <= got_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       port_q <= '0;
    else if (capture) port_q <= rx_byte;
  end

  assign done = sel && got_q;
endmodule

// File: rtl/pcall_ctrl.sv
module pcall_ctrl #(
  parameter int unsigned CODE_W    = pcall_pkg::CODE_W,
  parameter int unsigned BYTE_W    = pcall_pkg::BYTE_W,
  parameter int unsigned CODE_SIN  = pcall_pkg::CODE_SIN,
  parameter int unsigned CODE_SOUT = pcall_pkg::CODE_SOUT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nop_valid,
  input  logic [CODE_W-1:0] nop_operand,
  output logic              busy,
  output logic [CODE_W-1:0] pending_code,
  input  logic [BYTE_W-1:0] ser_out_port,
  output logic [BYTE_W-1:0] tx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              rx_strobe,
  output logic [BYTE_W-1:0] ser_in_port
);
  localparam logic [CODE_W-1:0] SIN_C  = CODE_W'(CODE_SIN);
  localparam logic [CODE_W-1:0] SOUT_C = CODE_W'(CODE_SOUT);

  logic              rst_n_int;
  logic [CODE_W-1:0] code_q;
  logic              sel_sin;
  logic              sel_sout;
  logic              sel_other;
  logic              done_sin;
  logic              done_sout;
  logic              done_any;

  pcall_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  pcall_code_reg #(.CODE_W(CODE_W)) u_code (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .nop_valid   (nop_valid),
    .nop_operand (nop_operand),
    .done        (done_any),
    .code_q      (code_q)
  );

  always_comb begin
    sel_sin   = (code_q == SIN_C);
    sel_sout  = (code_q == SOUT_C);
    sel_other = (code_q != '0) && !sel_sin && !sel_sout;
    done_any  = done_sin || done_sout || sel_other;
  end

  pcall_tx_adapter #(.BYTE_W(BYTE_W)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .sel       (sel_sout),
    .port_byte (ser_out_port),
    .tx_ready  (tx_ready),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .done      (done_sout)
  );

  pcall_rx_adapter #(.BYTE_W(BYTE_W)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .sel       (sel_sin),
    .rx_strobe (rx_strobe),
    .rx_byte   (rx_byte),
    .port_q    (ser_in_port),
    .done      (done_sin)
  );

  assign pending_code = code_q;
  assign busy         = (code_q != '0);
endmodule

// File: rtl/pcall_ctrl_chk.sv
module pcall_ctrl_chk #(
  parameter int unsigned CODE_W    = 5,
  parameter int unsigned BYTE_W    = 8,
  parameter int unsigned CODE_SIN  = 1,
  parameter int unsigned CODE_SOUT = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              nop_valid,
  input logic [CODE_W-1:0] nop_operand,
  input logic              busy,
  input logic [CODE_W-1:0] pending_code,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic              rx_strobe,
  input logic [BYTE_W-1:0] ser_in_port
);
  localparam logic [CODE_W-1:0] SIN_C  = CODE_W'(CODE_SIN);
  localparam logic [CODE_W-1:0] SOUT_C = CODE_W'(CODE_SOUT);

  p_zero_nop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && nop_valid && nop_operand == '0) |=> !busy);

  p_call_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && nop_valid && nop_operand != '0) |=> (busy && pending_code == $past(nop_operand)));

  p_tx_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> (busy && !tx_valid) ##1 !busy);

  p_rx_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_strobe && pending_code == SIN_C) |=> $stable(ser_in_port));

  p_odd_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && pending_code != SIN_C && pending_code != SOUT_C) |=> !busy);

  p_hold_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (pending_code == $past(pending_code)));

  p_tx_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (pending_code == SOUT_C));
endmodule

bind pcall_ctrl pcall_ctrl_chk #(
  .CODE_W(CODE_W), .BYTE_W(BYTE_W), .CODE_SIN(CODE_SIN), .CODE_SOUT(CODE_SOUT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .nop_valid(nop_valid), .nop_operand(nop_operand),
  .busy(busy), .pending_code(pending_code), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .rx_strobe(rx_strobe), .ser_in_port(ser_in_port)
);

// File: tb/tb_pcall_ctrl.sv
`timescale 1ns/1ps
module tb_pcall_ctrl;
  logic       clk;
  logic       rst_n;
  logic       nop_valid;
  logic [4:0] nop_operand;
  logic       busy;
  logic [4:0] pending_code;
  logic [7:0] ser_out_port;
  logic [7:0] tx_data;
  logic       tx_valid;
  logic       tx_ready;
  logic [7:0] rx_byte;
  logic       rx_strobe;
  logic [7:0] ser_in_port;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  pcall_ctrl dut (
    .clk(clk), .rst_n(rst_n), .nop_valid(nop_valid), .nop_operand(nop_operand),
    .busy(busy), .pending_code(pending_code), .ser_out_port(ser_out_port),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_byte(rx_byte), .rx_strobe(rx_strobe), .ser_in_port(ser_in_port)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic issue(input logic [4:0] op);
    nop_valid   = 1'b1;
    nop_operand = op;
    step();
    nop_valid   = 1'b0;
    nop_operand = '0;
  endtask

  task automatic t_reset();
    check("R1 busy", busy, 0);
    check("R1 pending_code", pending_code, 0);
    check("R1 tx_valid", tx_valid, 0);
    check("R1 ser_in_port", ser_in_port, 0);
  endtask

  task automatic t_zero_nop();
    issue(5'd0);
    check("R2 busy", busy, 0);
    check("R2 pending_code", pending_code, 0);
  endtask

  task automatic t_tx_call();
    ser_out_port = 8'h5A;
    issue(5'd2);
    check("R3 busy", busy, 1);
    check("R3 pending_code", pending_code, 2);
    for (int i = 0; i < 3; i++) begin
      check("R4 tx_valid held", tx_valid, 1);
      check("R4 tx_data", tx_data, 8'h5A);
      check("R3 busy held", busy, 1);
      step();
    end
    tx_ready = 1'b1;
    step();
    tx_ready = 1'b0;
    check("R5 tx_valid drop", tx_valid, 0);
    check("R5 busy still", busy, 1);
    step();
    check("R5 busy released", busy, 0);
    check("R10 tx_valid idle", tx_valid, 0);
  endtask

  task automatic t_rx_call();
    issue(5'd1);
    check("R3 pending rx", pending_code, 1);
    check("R10 no tx on rx call", tx_valid, 0);
    step();
    check("R6 busy waiting", busy, 1);
    rx_byte   = 8'hA5;
    rx_strobe = 1'b1;
    step();
    rx_strobe = 1'b0;
    check("R6 ser_in_port", ser_in_port, 8'hA5);
    check("R6 busy still", busy, 1);
    step();
    check("R6 busy released", busy, 0);
  endtask

  task automatic t_rx_ignored();
    rx_byte   = 8'h3C;
    rx_strobe = 1'b1;
    step();
    rx_strobe = 1'b0;
    check("R7 strobe while idle", ser_in_port, 8'hA5);
    ser_out_port = 8'h11;
    issue(5'd2);
    rx_byte   = 8'h77;
    rx_strobe = 1'b1;
    step();
    rx_strobe = 1'b0;
    check("R7 strobe during tx call", ser_in_port, 8'hA5);
    tx_ready = 1'b1;
    step();
    tx_ready = 1'b0;
    step();
    check("R7 tx call done", busy, 0);
  endtask

  task automatic t_odd_code();
    issue(5'd7);
    check("R8 busy one cycle", busy, 1);
    check("R8 pending", pending_code, 7);
    check("R10 no tx on odd code", tx_valid, 0);
    step();
    check("R8 released", busy, 0);
  endtask

  task automatic t_nop_while_busy();
    ser_out_port = 8'hC3;
    issue(5'd2);
    issue(5'd1);
    check("R9 code kept", pending_code, 2);
    check("R9 tx_valid kept", tx_valid, 1);
    tx_ready = 1'b1;
    step();
    tx_ready = 1'b0;
    step();
    check("R9 released by original code", busy, 0);
    check("R9 no late call", pending_code, 0);
  endtask

  initial begin
    rst_n = 1'b0; nop_valid = 1'b0; nop_operand = '0; ser_out_port = '0;
    tx_ready = 1'b0; rx_byte = '0; rx_strobe = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (3) step();
    t_reset();
    t_zero_nop();
    t_tx_call();
    t_rx_call();
    t_rx_ignored();
    t_odd_code();
    t_nop_while_busy();
    step();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule